// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block paces conversions for an on-chip successive-approximation converter. An 8-bit control register, written through a simple write strobe, holds six settings:

- a power switch;
- a reference choice;
- a divider code that derives the converter clock from the master clock;
- an acquisition-length code;
- an enable for starting on a timer overflow;
- an enable for starting on an active-low external convert pin.

Once started, the sequencer runs a track phase lasting a programmable number of converter clocks. It then runs a conversion phase of a fixed number of converter clocks, and it signals completion with a single-cycle done pulse.

The converter clock is produced as a one-cycle enable pulse in the master-clock domain. The divider restarts at each conversion start, so each phase lasts a whole number of divided periods measured from the start. The external pin is synchronised, and a rising edge counts only after a long enough low period. Settings are captured when a conversion starts. Clearing the power bit aborts a running conversion.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset the control register reads as 0x00, so the block is powered down. While control bit 7 is 0, no trigger starts a conversion and `adcClkEn` stays low.
- R2: `refSel` equals control bit 6 in every cycle after the register write that sets it (1 = external reference, 0 = internal band-gap).
- R3: Control bits 5:4 set the divide ratio R: code 00 gives 8, 01 gives 4, 10 gives 16 and 11 gives 32. When powered, `adcClkEn` is a one-cycle pulse every R master cycles. During a conversion it pulses in busy-cycle indices R-1, 2R-1, and so on, counting from 0 at the first busy cycle.
- R4: Control bits 3:2 set the acquisition length A in converter clocks: code 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4. `sampleStrobe` is a one-cycle pulse at busy-cycle index A*R, and it occurs only while busy.
- R5: The conversion phase lasts CONV_CLKS (default 16) converter clocks, so `busy` stays high for exactly (A+CONV_CLKS)*R cycles. `convDone` pulses for one cycle in the first cycle after `busy` falls.
- R6: A high `timerOvf` cycle starts a conversion only when control bit 1 is 1.
- R7: A rising edge on `convstN` starts a conversion only when control bit 0 is 1. The pin must have been low for at least MIN_LOW (default 8) consecutive master cycles before the edge; edges after shorter low periods are ignored.
- R8: A trigger arriving while `busy` is high is ignored. The running conversion keeps its length and produces exactly one done pulse.
- R9: A control-register write during a conversion does not change that conversion's timing. The new divider and acquisition codes apply from the next start.
- R10: Clearing control bit 7 during a conversion drops `busy` in the cycle after the register changes. No done pulse follows, and `adcClkEn` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control register write strobe |
| cfgWdata | input | 8 | Control register write data |
| timerOvf | input | 1 | Timer overflow pulse, one master cycle per overflow |
| convstN | input | 1 | External active-low convert pin, asynchronous |
| adcClkEn | output | 1 | Converter clock enable, one master cycle wide |
| sampleStrobe | output | 1 | Track-and-hold sample pulse at the end of acquisition |
| busy | output | 1 | High from conversion start until completion or abort |
| refSel | output | 1 | Reference select, 1 = external |
| convDone | output | 1 | One-cycle pulse on normal completion |

## Verification
The sequencer is exercised with every divider code and every acquisition code. Each code pair gives a distinct busy length and sample position, so a swapped code in either decoder shows up as a wrong cycle count. Timer and external triggers are each applied with only the other source enabled, which separates the two enable bits. External low pulses of 3, 7 and 8 cycles probe the minimum-width boundary. Further sequences send a second trigger, a control rewrite and a power-down in the middle of a conversion. These show whether a start can be re-entered, whether settings are held until the next start, and whether an abort ends the conversion cleanly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int DIV_W = 5;   // wide enough for a ratio of 32
  localparam int ACQ_W = 2;

  typedef struct packed {
    logic latchCfg;
    logic divClr;
    logic acqClr;
    logic acqInc;
    logic convClr;
    logic convInc;
  } seqStrobe_t;

  typedef struct packed {
    logic powerOn;
    logic trig;
    logic tick;
    logic acqLast;
    logic convLast;
  } seqStatus_t;

  // Non-monotonic divider encoding, returned as a power-of-two shift.
  function automatic logic [2:0] divShift(input logic [1:0] code);
    case (code)
      2'b00:   divShift = 3'd3;
      2'b01:   divShift = 3'd2;
      2'b10:   divShift = 3'd4;
      default: divShift = 3'd5;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] divLimit(input logic [1:0] code);
    logic [DIV_W:0] full;
    full = (DIV_W+1)'(1) << divShift(code);
    divLimit = DIV_W'(full - (DIV_W+1)'(1));
  endfunction

endpackage

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int MIN_LOW   = 8,
  parameter int CONV_CLKS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [7:0]  cfgWdata,
  input  logic        timerOvf,
  input  logic        convstN,
  input  logic        busy,
  input  seqStrobe_t  strobe,
  output seqStatus_t  status,
  output logic        adcClkEn,
  output logic        refSel
);

  localparam int LOW_W  = $clog2(MIN_LOW + 1);
  localparam int CONV_W = (CONV_CLKS > 1) ? $clog2(CONV_CLKS) : 1;
  localparam logic [LOW_W-1:0]  LOW_SAT   = LOW_W'(MIN_LOW);
  localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(CONV_CLKS - 1);

  // control register
  logic [7:0] cfgQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgWdata;
  end

  logic       powerOn, timerEn, extEn;
  logic [1:0] divCodeLive, acqCodeLive;
  assign powerOn     = cfgQ[7];
  assign refSel      = cfgQ[6];
  assign divCodeLive = cfgQ[5:4];
  assign acqCodeLive = cfgQ[3:2];
  assign timerEn     = cfgQ[1];
  assign extEn       = cfgQ[0];

  // settings captured at conversion start
  logic [1:0]       divCodeHeld;
  logic [ACQ_W-1:0] acqCodeHeld;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCodeHeld <= '0;
      acqCodeHeld <= '0;
    end else if (strobe.latchCfg) begin
      divCodeHeld <= divCodeLive;
      acqCodeHeld <= acqCodeLive;
    end
  end

  // converter clock divider
  logic [DIV_W-1:0] divCnt, divLim;
  logic             divWrap;
  assign divLim  = busy ? divLimit(divCodeHeld) : divLimit(divCodeLive);
  assign divWrap = (divCnt == divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         divCnt <= '0;
    else if (!powerOn || strobe.divClr) divCnt <= '0;
    else if (divWrap)                  divCnt <= '0;
    else                               divCnt <= divCnt + 1'b1;
  end

  assign adcClkEn = powerOn && divWrap;

  // external pin: two-stage synchroniser plus edge history
  logic syncA, syncB, syncC;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
      syncC <= 1'b1;
    end else begin
      syncA <= convstN;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  // saturating low-period counter
  logic [LOW_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lowCnt <= '0;
    else if (syncB)             lowCnt <= '0;
    else if (lowCnt != LOW_SAT) lowCnt <= lowCnt + 1'b1;
  end

  logic extRise, extQualified;
  assign extRise      = syncB && !syncC;
  assign extQualified = extRise && (lowCnt >= LOW_SAT);

  // trigger qualification
  logic timerHit, extHit;
  assign timerHit = timerEn && timerOvf;
  assign extHit   = extEn && extQualified;

  // acquisition counter
  logic [ACQ_W-1:0] acqCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              acqCnt <= '0;
    else if (strobe.acqClr) acqCnt <= '0;
    else if (strobe.acqInc) acqCnt <= acqCnt + 1'b1;
  end

  // conversion counter
  logic [CONV_W-1:0] convCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               convCnt <= '0;
    else if (strobe.convClr) convCnt <= '0;
    else if (strobe.convInc) convCnt <= convCnt + 1'b1;
  end

  assign status.powerOn  = powerOn;
  assign status.trig     = powerOn && !busy && (timerHit || extHit);
  assign status.tick     = adcClkEn;
  assign status.acqLast  = (acqCnt == acqCodeHeld);
  assign status.convLast = (convCnt == CONV_LAST);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       sampleStrobe,
  output logic       convDone
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seqState_t;

  seqState_t state, stateNext;
  logic      sampleNext, doneNext;

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    sampleNext = 1'b0;
    doneNext   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (status.trig) begin
          strobe.latchCfg = 1'b1;
          strobe.divClr   = 1'b1;
          strobe.acqClr   = 1'b1;
          stateNext       = ST_ACQ;
        end
      end
      ST_ACQ: begin
        if (!status.powerOn) begin
          stateNext = ST_IDLE;
        end else if (status.tick) begin
          if (status.acqLast) begin
            strobe.convClr = 1'b1;
            sampleNext     = 1'b1;
            stateNext      = ST_CONV;
          end else begin
            strobe.acqInc = 1'b1;
          end
        end
      end
      ST_CONV: begin
        if (!status.powerOn) begin
          stateNext = ST_IDLE;
        end else if (status.tick) begin
          if (status.convLast) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.convInc = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      sampleStrobe <= 1'b0;
      convDone     <= 1'b0;
    end else begin
      state        <= stateNext;
      sampleStrobe <= sampleNext;
      convDone     <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int MIN_LOW   = 8,
  parameter int CONV_CLKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [7:0] cfgWdata,
  input  logic       timerOvf,
  input  logic       convstN,
  output logic       adcClkEn,
  output logic       sampleStrobe,
  output logic       busy,
  output logic       refSel,
  output logic       convDone
);

  seqStrobe_t strobe;
  seqStatus_t status;

  adc_seq_dp #(
    .MIN_LOW  (MIN_LOW),
    .CONV_CLKS(CONV_CLKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .timerOvf (timerOvf),
    .convstN  (convstN),
    .busy     (busy),
    .strobe   (strobe),
    .status   (status),
    .adcClkEn (adcClkEn),
    .refSel   (refSel)
  );

  adc_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .status       (status),
    .strobe       (strobe),
    .busy         (busy),
    .sampleStrobe (sampleStrobe),
    .convDone     (convDone)
  );

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic [7:0] cfgWdata,
  input logic       adcClkEn,
  input logic       sampleStrobe,
  input logic       busy,
  input logic       refSel,
  input logic       convDone
);

  // Register image rebuilt from the write port alone.
  logic powerQ, refQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerQ <= 1'b0;
      refQ   <= 1'b0;
    end else if (cfgWe) begin
      powerQ <= cfgWdata[7];
      refQ   <= cfgWdata[6];
    end
  end

  AST_NO_CLKEN_POWERED_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    !powerQ |-> !adcClkEn);                                   // R1
  AST_NO_START_POWERED_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !powerQ) |=> !busy);                            // R1
  AST_REF_TRACKS_REG: assert property (@(posedge clk) disable iff (!rstN)
    refSel == refQ);                                          // R2
  AST_CLKEN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    adcClkEn |=> !adcClkEn);                                  // R3
  AST_SAMPLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> busy);                                   // R4
  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);                          // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);                                  // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> (!busy && $past(busy)));                     // R5
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !powerQ) |=> (!busy && !convDone));              // R10

endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgWe        (cfgWe),
  .cfgWdata     (cfgWdata),
  .adcClkEn     (adcClkEn),
  .sampleStrobe (sampleStrobe),
  .busy         (busy),
  .refSel       (refSel),
  .convDone     (convDone)
);

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;

  localparam int CONV = 16;
  localparam int WIN  = 800;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgWdata = '0;
  logic       timerOvf = 1'b0;
  logic       convstN = 1'b1;
  logic       adcClkEn, sampleStrobe, busy, refSel, convDone;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  adc_conv_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .timerOvf(timerOvf), .convstN(convstN), .adcClkEn(adcClkEn),
    .sampleStrobe(sampleStrobe), .busy(busy), .refSel(refSel),
    .convDone(convDone)
  );

  // src: 0 = timer pulse, 1 = external low pulse
  typedef struct packed {
    logic [7:0] cfg;
    logic       src;
    logic [7:0] lowLen;
    logic       expStart;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h82, 1'b0, 8'd0,  1'b1},  // div 8,  acq 1, timer     R3 R4 R5 R6
    '{8'h96, 1'b0, 8'd0,  1'b1},  // div 4,  acq 2, timer
    '{8'hA9, 1'b1, 8'd10, 1'b1},  // div 16, acq 3, external  R7
    '{8'hBD, 1'b1, 8'd20, 1'b1},  // div 32, acq 4, external
    '{8'h8E, 1'b0, 8'd0,  1'b1},  // div 8,  acq 4, timer
    '{8'hB6, 1'b0, 8'd0,  1'b1},  // div 32, acq 2, timer
    '{8'h81, 1'b0, 8'd0,  1'b0},  // timer not enabled        R6
    '{8'h82, 1'b1, 8'd12, 1'b0},  // external not enabled     R7
    '{8'h81, 1'b1, 8'd3,  1'b0},  // low too short            R7
    '{8'h81, 1'b1, 8'd7,  1'b0},  // one cycle short          R7
    '{8'h81, 1'b1, 8'd8,  1'b1},  // exactly minimum          R7
    '{8'h02, 1'b0, 8'd0,  1'b0}   // powered down             R1
  };

  function automatic int expRatio(input logic [7:0] c);
    case (c[5:4])
      2'b00: return 8;
      2'b01: return 4;
      2'b10: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int expAcq(input logic [7:0] c);
    return int'(c[3:2]) + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseTimer();
    @(negedge clk);
    timerOvf = 1'b1;
    @(negedge clk);
    timerOvf = 1'b0;
  endtask

  task automatic pulseExt(input int lowLen);
    @(negedge clk);
    convstN = 1'b0;
    for (int i = 0; i < lowLen; i++) @(negedge clk);
    convstN = 1'b1;
  endtask

  task automatic observe(input int cycles, output int busyCyc, output int sampIdx,
                         output int tickCnt, output int doneCnt, output int idleTicks);
    busyCyc = 0; sampIdx = -1; tickCnt = 0; doneCnt = 0; idleTicks = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy) begin
        if (sampleStrobe) sampIdx = busyCyc;
        if (adcClkEn) tickCnt++;
        busyCyc++;
      end else if (adcClkEn) begin
        idleTicks++;
      end
      if (convDone) doneCnt++;
    end
  endtask

  int bc, si, tc, dc, it;

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R1, R2)
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 clkEn at reset", int'(adcClkEn), 0);
    chk("R5 done at reset", int'(convDone), 0);
    chk("R4 strobe at reset", int'(sampleStrobe), 0);
    chk("R2 refSel at reset", int'(refSel), 0);
    rstN = 1'b1;

    // R1: no converter clock while powered down
    observe(100, bc, si, tc, dc, it);
    chk("R1 clkEn while down", it, 0);

    // R2: reference select follows bit 6
    writeCfg(8'h40);
    chk("R2 refSel set", int'(refSel), 1);
    writeCfg(8'h00);
    chk("R2 refSel clear", int'(refSel), 0);

    // R3: idle divider pulse rates
    writeCfg(8'h90);
    observe(40, bc, si, tc, dc, it);
    chk("R3 div4 pulses in 40", it, 10);
    writeCfg(8'hB0);
    observe(64, bc, si, tc, dc, it);
    chk("R3 div32 pulses in 64", it, 2);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      int r, a;
      r = expRatio(VECS[v].cfg);
      a = expAcq(VECS[v].cfg);
      writeCfg(VECS[v].cfg);
      repeat (4) @(negedge clk);
      fork
        begin
          if (VECS[v].src) pulseExt(int'(VECS[v].lowLen));
          else pulseTimer();
        end
        observe(WIN, bc, si, tc, dc, it);
      join
      if (VECS[v].expStart) begin
        chk($sformatf("R5 busy length vec%0d", v), bc, (a + CONV) * r);
        chk($sformatf("R4 sample index vec%0d", v), si, a * r);
        chk($sformatf("R3 ticks in busy vec%0d", v), tc, a + CONV);
        chk($sformatf("R5 done count vec%0d", v), dc, 1);
      end else begin
        chk($sformatf("R6 R7 R1 no start vec%0d", v), bc, 0);
        chk($sformatf("R6 R7 R1 no done vec%0d", v), dc, 0);
      end
      if (VECS[v].cfg[7] == 1'b0) chk("R1 no clkEn down", it, 0);
    end

    // R8: retrigger while busy is ignored
    writeCfg(8'h83);
    fork
      begin
        pulseTimer();
        repeat (50) @(negedge clk);
        pulseTimer();
        pulseExt(12);
      end
      observe(WIN, bc, si, tc, dc, it);
    join
    chk("R8 busy length unchanged", bc, 17 * 8);
    chk("R8 single done", dc, 1);

    // R9: rewrite during conversion, new codes at next start
    writeCfg(8'h82);
    fork
      begin
        pulseTimer();
        repeat (30) @(negedge clk);
        writeCfg(8'h9E);
      end
      observe(WIN, bc, si, tc, dc, it);
    join
    chk("R9 running conversion kept", bc, 17 * 8);
    chk("R9 running sample kept", si, 8);
    fork
      pulseTimer();
      observe(WIN, bc, si, tc, dc, it);
    join
    chk("R9 next start uses new codes", bc, 20 * 4);
    chk("R9 next sample uses new codes", si, 16);

    // R10: power-down abort
    writeCfg(8'h82);
    fork
      begin
        pulseTimer();
        repeat (20) @(negedge clk);
        writeCfg(8'h02);
      end
      observe(300, bc, si, tc, dc, it);
    join
    chk("R10 aborted early", int'(bc >= 18 && bc <= 24), 1);
    chk("R10 no done on abort", dc, 0);
    chk("R10 no clkEn after abort", it, 0);
    chk("R10 idle after abort", int'(busy), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule